// File: doc/BRIEF.md
# Hop-Addressed Reconfigurable Grid Cell

One cell for a square array of identical cells. Each cell has four neighbour sides, numbered north = 0, east = 1, south = 2 and west = 3. Every side carries a link word in each direction. A link word is a one-bit program flag plus a `DW`-bit data value. Once configured, the cell watches one selected input side and drives at most one selected output side. Every other output is held at zero with the flag clear. Every output is registered, so each result appears one clock after its input is sampled.

A programming word travels through the array as an ordinary link word with the flag set. Each cell that passes it on lowers its data value by one. The cell that receives it with a value of zero consumes it and then takes its new configuration over that same side. The configuration is wider than one link word, so it arrives as several consecutive chunks. The configuration selects one of four modes:

- plain routing;
- a 16-entry one-bit lookup function;
- a storage word that can be read and written;
- idle.

A neighbour, or a controller at the array edge, can therefore reconfigure any cell along a chain while other cells keep working.

Top module: `hgc_cell`

## Requirements
- R1: After synchronous reset every output flag and data bit is zero, the cell is idle, and it forwards nothing (neither plain words nor flagged words with a nonzero count) until it has been programmed.
- R2: In idle mode, a flagged word with data zero on any side starts a configuration load over that side; when several sides carry one in the same cycle, the lowest-numbered side (north 0, east 1, south 2, west 3) wins.
- R3: In a non-idle mode only the selected input side is watched; a flagged word with data zero on it is consumed, all outputs are zero in the following cycle, and a load begins on that side.
- R4: In a non-idle mode, a flagged word with nonzero data d on the selected input appears one cycle later on the selected output with the flag set and data d-1, whatever the mode.
- R5: A load takes the data fields of the next NCHUNK consecutive words on the loading side (3 for DW = 8), chunk 0 at the lowest configuration bits, whatever their flags. All outputs are zero for the whole load, and the new configuration governs the cycle after the last chunk.
- R6: Configuration bit layout: [1:0] mode (00 route, 01 lookup, 10 storage, 11 idle), [3:2] input side, [5:4] output side, [21:6] lookup table (bit i is the result for index i).
- R7: Route mode: an unflagged word on the selected input is copied unchanged, with the flag clear, to the selected output one cycle later.
- R8: Lookup mode: an unflagged word on the selected input drives the selected output one cycle later with flag clear, bit 0 equal to table bit data[3:0], and all other bits zero.
- R9: Storage mode: an unflagged word with its top data bit set writes its low DW-1 bits into the stored word and drives nothing. An unflagged word with its top bit clear drives the stored word, with a zero top bit, on the selected output one cycle later.
- R10: Idle mode loaded by configuration behaves like reset idle: outputs stay zero while words of any kind arrive. In every mode at most one output flag is set per cycle.
- R11: The stored word is kept unchanged through loads and mode changes; only reset and storage-mode writes alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_prog | input | 4 | Program flag of the incoming word, one bit per side |
| in_data | input | 4*DW | Incoming data words, side s at bits [s*DW +: DW] |
| out_prog | output | 4 | Program flag of the outgoing word, one bit per side |
| out_data | output | 4*DW | Outgoing data words, side s at bits [s*DW +: DW] |

## Verification
On every cycle, the assertions check three properties: outputs are silent during a load and in idle mode, at most one output flag is raised, and a nonzero flagged word always yields an output flag. They also check that a zero-count trigger on the watched side always opens a load, that the chunk counter stays in range, and that the stored word does not change during a load. The actual data values can be shown only by the bench scenarios, compared cycle by cycle against a behavioural model. These cover the lowered hop count, the chunk ordering into the configuration fields, the lookup results for all sixteen indices, the storage read-back and its survival across reprogramming, and the side priority among simultaneous idle triggers.

// File: rtl/hgc_pkg.sv
package hgc_pkg;

    localparam int SIDES    = 4;
    localparam int SIDE_W   = 2;
    localparam int LUT_IDX  = 4;
    localparam int LUT_BITS = 1 << LUT_IDX;
    localparam int CFG_W    = 2 + 2 * SIDE_W + LUT_BITS;

    typedef enum logic [1:0] {
        MODE_ROUTE = 2'b00,
        MODE_LUT   = 2'b01,
        MODE_STORE = 2'b10,
        MODE_IDLE  = 2'b11
    } mode_e;

    // packed: first member is most significant, so mode sits at [1:0]
    typedef struct packed {
        logic [LUT_BITS-1:0] lut_bits;
        logic [SIDE_W-1:0]   out_side;
        logic [SIDE_W-1:0]   in_side;
        mode_e               mode;
    } cfg_t;

endpackage

// File: rtl/hgc_port_pick.sv
module hgc_port_pick
    import hgc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [SIDES-1:0]    in_prog,
    input  logic [SIDES*DW-1:0] in_data,
    input  logic [SIDE_W-1:0]   sel,
    output logic                sel_prog,
    output logic [DW-1:0]       sel_data,
    output logic                sel_zero,
    output logic                any_trig,
    output logic [SIDE_W-1:0]   trig_side
);

    logic [DW-1:0]    words [SIDES];
    logic [SIDES-1:0] is_trig;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        assign words[g]   = in_data[g*DW +: DW];
        assign is_trig[g] = in_prog[g] && (words[g] == '0);
    end

    assign sel_prog = in_prog[sel];
    assign sel_data = words[sel];
    assign sel_zero = (sel_data == '0);
    assign any_trig = |is_trig;

    // lowest-numbered side has priority
    always_comb begin
        trig_side = '0;
        for (int i = SIDES - 1; i >= 0; i--) begin
            if (is_trig[i]) trig_side = SIDE_W'(i);
        end
    end

endmodule

// File: rtl/hgc_func.sv
module hgc_func
    import hgc_pkg::*;
#(
    parameter int DW = 8
) (
    input  mode_e               mode,
    input  logic [LUT_BITS-1:0] lut_bits,
    input  logic [DW-1:0]       sel_data,
    input  logic [DW-2:0]       store_q,
    output logic                fn_valid,
    output logic [DW-1:0]       fn_data,
    output logic                st_write,
    output logic [DW-2:0]       st_wdata
);

    always_comb begin
        fn_valid = 1'b0;
        fn_data  = '0;
        st_write = 1'b0;
        st_wdata = sel_data[DW-2:0];
        unique case (mode)
            MODE_ROUTE: begin
                fn_valid = 1'b1;
                fn_data  = sel_data;
            end
            MODE_LUT: begin
                fn_valid = 1'b1;
                fn_data  = {{(DW-1){1'b0}}, lut_bits[sel_data[LUT_IDX-1:0]]};
            end
            MODE_STORE: begin
                if (sel_data[DW-1]) begin
                    st_write = 1'b1;
                end else begin
                    fn_valid = 1'b1;
                    fn_data  = {1'b0, store_q};
                end
            end
            default: begin
                fn_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hgc_loader.sv
module hgc_loader
    import hgc_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NCHUNK = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [SIDE_W-1:0]    start_side,
    input  logic [SIDES*DW-1:0]  in_data,
    output logic                 busy,
    output logic                 done,
    output logic [NCHUNK*DW-1:0] word
);

    localparam int ACC_W = NCHUNK * DW;
    localparam int CNT_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    typedef struct packed {
        logic              busy;
        logic [SIDE_W-1:0] side;
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc;
    } ld_t;

    ld_t ld_d, ld_q;
    logic [DW-1:0]    chunk;
    logic [ACC_W-1:0] shifted;

    assign chunk = in_data[int'(ld_q.side)*DW +: DW];

    // chunks shift in from the top, so the first one ends lowest
    if (NCHUNK == 1) begin : g_single
        assign shifted = chunk;
    end else begin : g_multi
        assign shifted = {chunk, ld_q.acc[ACC_W-1:DW]};
    end

    always_comb begin
        ld_d = ld_q;
        done = 1'b0;
        if (ld_q.busy) begin
            ld_d.acc = shifted;
            if (ld_q.cnt == CNT_W'(NCHUNK - 1)) begin
                done      = 1'b1;
                ld_d.busy = 1'b0;
                ld_d.cnt  = '0;
            end else begin
                ld_d.cnt = ld_q.cnt + CNT_W'(1);
            end
        end else if (start) begin
            ld_d.busy = 1'b1;
            ld_d.side = start_side;
            ld_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ld_q <= '0;
        else     ld_q <= ld_d;
    end

    assign busy = ld_q.busy;
    assign word = shifted;

    // R5
    chunk_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        ld_q.busy |-> (int'(ld_q.cnt) < NCHUNK));

    // R5
    load_ends_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !ld_q.busy);

endmodule

// File: rtl/hgc_cell.sv
module hgc_cell
    import hgc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SIDES-1:0]    in_prog,
    input  logic [SIDES*DW-1:0] in_data,
    output logic [SIDES-1:0]    out_prog,
    output logic [SIDES*DW-1:0] out_data
);

    localparam int NCHUNK = (CFG_W + DW - 1) / DW;
    localparam int ACC_W  = NCHUNK * DW;

    typedef struct packed {
        cfg_t                cfg;
        logic [DW-2:0]       store;
        logic [SIDES-1:0]    oprog;
        logic [SIDES*DW-1:0] odata;
    } cell_t;

    cell_t st_d, st_q;

    logic              sel_prog, sel_zero, any_trig;
    logic [DW-1:0]     sel_data;
    logic [SIDE_W-1:0] trig_side;
    logic              fn_valid, st_write;
    logic [DW-1:0]     fn_data;
    logic [DW-2:0]     st_wdata;
    logic              ld_start, ld_busy, ld_done;
    logic [SIDE_W-1:0] ld_side;
    logic [ACC_W-1:0]  ld_word;

    hgc_port_pick #(.DW(DW)) u_pick (
        .in_prog   (in_prog),
        .in_data   (in_data),
        .sel       (st_q.cfg.in_side),
        .sel_prog  (sel_prog),
        .sel_data  (sel_data),
        .sel_zero  (sel_zero),
        .any_trig  (any_trig),
        .trig_side (trig_side)
    );

    hgc_func #(.DW(DW)) u_func (
        .mode     (st_q.cfg.mode),
        .lut_bits (st_q.cfg.lut_bits),
        .sel_data (sel_data),
        .store_q  (st_q.store),
        .fn_valid (fn_valid),
        .fn_data  (fn_data),
        .st_write (st_write),
        .st_wdata (st_wdata)
    );

    hgc_loader #(.DW(DW), .NCHUNK(NCHUNK)) u_load (
        .clk        (clk),
        .rst        (rst),
        .start      (ld_start),
        .start_side (ld_side),
        .in_data    (in_data),
        .busy       (ld_busy),
        .done       (ld_done),
        .word       (ld_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.oprog = '0;
        st_d.odata = '0;
        ld_start   = 1'b0;
        ld_side    = st_q.cfg.in_side;
        if (ld_busy) begin
            if (ld_done) st_d.cfg = cfg_t'(ld_word[CFG_W-1:0]);
        end else if (st_q.cfg.mode == MODE_IDLE) begin
            if (any_trig) begin
                ld_start = 1'b1;
                ld_side  = trig_side;
            end
        end else if (sel_prog) begin
            if (sel_zero) begin
                ld_start = 1'b1;
            end else begin
                st_d.oprog[st_q.cfg.out_side] = 1'b1;
                st_d.odata[int'(st_q.cfg.out_side)*DW +: DW] = sel_data - DW'(1);
            end
        end else begin
            if (fn_valid) st_d.odata[int'(st_q.cfg.out_side)*DW +: DW] = fn_data;
            if (st_write) st_d.store = st_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            st_q.cfg.mode <= MODE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_prog = st_q.oprog;
    assign out_data = st_q.odata;

    // R5
    quiet_during_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_busy |=> (out_prog == '0 && out_data == '0));

    // R10
    idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cfg.mode == MODE_IDLE && !ld_busy) |=> (out_prog == '0 && out_data == '0));

    // R10
    single_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_prog));

    // R4
    hop_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_busy && st_q.cfg.mode != MODE_IDLE && sel_prog && !sel_zero)
        |=> ($countones(out_prog) == 1));

    // R3
    trigger_opens_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_busy && st_q.cfg.mode != MODE_IDLE && sel_prog && sel_zero)
        |=> (ld_busy && out_prog == '0));

    // R11
    store_held_in_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_busy |=> $stable(st_q.store));

endmodule

// File: tb/hgc_cell_test.sv
module hgc_cell_test;

    localparam int DW  = 8;
    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic [3:0]      in_p;
    logic [4*DW-1:0] in_d;
    logic [3:0]      out_p;
    logic [4*DW-1:0] out_d;

    always #10 clk = ~clk;

    hgc_cell #(.DW(DW)) uut (
        .clk      (clk),
        .rst      (rst),
        .in_prog  (in_p),
        .in_data  (in_d),
        .out_prog (out_p),
        .out_data (out_d)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference state
    int          m_mode, m_in, m_out, m_lut, m_store, m_ld, m_cnt, m_side;
    longint      m_acc;
    logic [3:0]      e_p;
    logic [4*DW-1:0] e_d;

    function automatic int word_of(int s);
        return int'(in_d[s*DW +: DW]);
    endfunction

    function automatic logic [4*DW-1:0] on(int s, int v);
        logic [4*DW-1:0] r;
        r = '0;
        r[s*DW +: DW] = v[DW-1:0];
        return r;
    endfunction

    function automatic int mk(int mode, int ins, int outs, int lut);
        return mode | (ins << 2) | (outs << 4) | (lut << 6);
    endfunction

    task automatic model_reset();
        m_mode = 3; m_in = 0; m_out = 0; m_lut = 0; m_store = 0;
        m_ld = 0; m_cnt = 0; m_side = 0; m_acc = 0;
        e_p = '0; e_d = '0;
    endtask

    task automatic model_begin_load(int s);
        m_ld = 1; m_cnt = 0; m_acc = 0; m_side = s;
    endtask

    task automatic model_step();
        int d;
        e_p = '0;
        e_d = '0;
        if (m_ld != 0) begin
            m_acc = m_acc | (longint'(word_of(m_side)) << (DW * m_cnt));
            m_cnt++;
            if (m_cnt == NCH) begin
                m_mode = int'(m_acc & 3);
                m_in   = int'((m_acc >> 2) & 3);
                m_out  = int'((m_acc >> 4) & 3);
                m_lut  = int'((m_acc >> 6) & 16'hFFFF);
                m_ld   = 0;
            end
        end else if (m_mode == 3) begin
            for (int s = 3; s >= 0; s--) begin
                if (in_p[s] && word_of(s) == 0) begin
                    m_side = s;
                    m_ld   = 2;
                end
            end
            if (m_ld == 2) model_begin_load(m_side);
        end else begin
            d = word_of(m_in);
            if (in_p[m_in]) begin
                if (d == 0) model_begin_load(m_in);
                else begin
                    e_p[m_out] = 1'b1;
                    e_d[m_out*DW +: DW] = DW'(d - 1);
                end
            end else if (m_mode == 0) begin
                e_d[m_out*DW +: DW] = DW'(d);
            end else if (m_mode == 1) begin
                e_d[m_out*DW +: DW] = DW'((m_lut >> (d & 15)) & 1);
            end else if (((d >> (DW - 1)) & 1) != 0) begin
                m_store = d & ((1 << (DW - 1)) - 1);
            end else begin
                e_d[m_out*DW +: DW] = DW'(m_store);
            end
        end
    endtask

    task automatic check(string req, logic [4*DW+3:0] act, logic [4*DW+3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, advance model after posedge, compare at next negedge
    task automatic step(logic [3:0] p, logic [4*DW-1:0] d);
        in_p = p;
        in_d = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, {out_p, out_d}, {e_p, e_d});
    endtask

    task automatic load_cfg(int side, int cfg);
        for (int i = 0; i < NCH; i++) step(4'b0000, on(side, (cfg >> (DW * i)) & 255));
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        rst  = 1'b1;
        in_p = '0;
        in_d = '0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", {out_p, out_d}, '0);
        cur_req = "R1";
        step(4'b0000, on(0, 8'h5A));
        step(4'b0001, on(0, 5));
        step(4'b0100, on(2, 1));

        // R2: simultaneous triggers on east and south, east wins
        cur_req = "R2";
        step(4'b0110, '0);
        // R5 R6: chunks on east; south traffic must be ignored
        cur_req = "R5";
        in_p = '0;
        for (int i = 0; i < NCH; i++)
            step(4'b0100, on(1, (mk(0, 1, 3, 0) >> (DW * i)) & 255) | on(2, 8'h77));

        // R7: route east -> west
        cur_req = "R7";
        step(4'b0000, on(1, 8'h5A));
        step(4'b0000, on(1, 8'hC3) | on(0, 8'h11));
        // R3: unselected side carries a trigger, ignored
        cur_req = "R3";
        step(4'b0001, on(0, 0) | on(1, 8'h22));
        // R4: hop count lowered
        cur_req = "R4";
        step(4'b0010, on(1, 5));
        step(4'b0010, on(1, 1));
        step(4'b0010, on(1, 8'hFF));

        // R3: trigger on selected side, then lookup config: in north, out south, parity table
        cur_req = "R3";
        step(4'b0010, on(1, 0));
        cur_req = "R6";
        load_cfg(1, mk(1, 0, 2, 16'h6996));
        // R8: all sixteen indices, upper data bits set to prove they are ignored
        cur_req = "R8";
        for (int i = 0; i < 16; i++) step(4'b0000, on(0, 8'hA0 | i));
        cur_req = "R4";
        step(4'b0001, on(0, 3));

        // R9: storage mode, in north, out east
        cur_req = "R9";
        step(4'b0001, on(0, 0));
        load_cfg(0, mk(2, 0, 1, 0));
        step(4'b0000, on(0, 8'h80 | 8'h33));
        step(4'b0000, on(0, 8'h00));
        step(4'b0000, on(0, 8'hFF));
        step(4'b0000, on(0, 8'h01));

        // R10: configure idle, everything ignored
        cur_req = "R10";
        step(4'b0001, on(0, 0));
        load_cfg(0, mk(3, 2, 2, 16'hFFFF));
        step(4'b0000, on(0, 8'h44) | on(2, 8'h55));
        step(4'b1111, on(0, 2) | on(1, 3) | on(2, 4) | on(3, 5));

        // R11: reprogram from west into storage, stored word survives
        cur_req = "R11";
        step(4'b1000, on(3, 0));
        load_cfg(3, mk(2, 3, 0, 0));
        step(4'b0000, on(3, 8'h00));
        step(4'b0000, '0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

endmodule